// File: doc/BRIEF.md
# Bridge Error Status and Interrupt Logic

This block gathers error events raised by the logic of a PCI-to-internal-bus bridge. Each event lands in a sticky status bit. Every status bit has its own enable bit in a separate enable register, and a single registered interrupt line is raised while any enabled bit is set. Software finds the cause by reading the status register, and it acknowledges a bit by writing a one to that bit's position.

The block also shapes the completion of reads that the internal bus starts on the PCI side. Writes from the internal bus are posted: they have already finished on the internal side when the PCI transfer fails, so their failures reach software only through the interrupt. A failed read instead returns an error response in place of data. A configuration bit can turn that response off, in which case the read completes normally with zero data. The bridge logic raises the matching status event either way.

Top module: `brg_err_irq`

## Requirements
- R1: After reset the status and enable registers read zero, the configuration register reads 1 (error response on), `irq` is 0 and `ib_rvalid` is 0.
- R2: A one-cycle pulse on `err_evt[i]` sets status bit i at that clock edge, and the bit stays set until software clears it. Bit map: 0 TRDY timeout, 1 retry timeout, 2 broken master, 3 master data parity, 4 master parity, 5 master fatal, 6 data parity detected, 7 system error signalled, 8 target PERR seen, 9 target internal-bus error, 10 SERR seen.
- R3: A write to address 0 (status) clears each status bit whose data bit is 1 and leaves bits whose data bit is 0 unchanged.
- R4: When a clear and an event hit the same status bit in the same cycle, the bit stays set.
- R5: Address 1 is the enable register; bit i enables status bit i. It is written and read back directly.
- R6: `irq` is 1 exactly when some status bit and its enable bit are both 1, and it changes at the same clock edge as the register state that causes the change.
- R7: A cycle with `rd_done`=1 and `rd_err`=0 produces `ib_rvalid`=1 one clock later, with `ib_rdata` equal to `rd_data` and `ib_rerr`=0.
- R8: When `rd_done` and `rd_err` are both 1 and configuration bit 0 (address 2) is 1, the completion one clock later has `ib_rerr`=1 and `ib_rdata`=0.
- R9: When configuration bit 0 is 0, a failed read completes with `ib_rvalid`=1, `ib_rerr`=0 and `ib_rdata`=0.
- R10: A register read (`reg_re`) returns the addressed register's value from before that clock edge on `reg_rdata` one clock later. Address 3 and all unused upper bits read as 0.
- R11: Enable bits above the 11 implemented sources are not stored. Writing all ones to address 1 reads back as 0x7FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_evt | input | 11 | One-cycle error event pulses from the bridge, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 enable, 2 configuration, 3 reserved |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the clock after `reg_re` |
| rd_done | input | 1 | PCI side of an initiator read has finished |
| rd_err | input | 1 | The finished read failed on PCI |
| rd_data | input | 32 | Data returned by the finished read |
| ib_rvalid | output | 1 | Read completion toward the internal bus |
| ib_rdata | output | 32 | Completion data |
| ib_rerr | output | 1 | Completion carries a bus error response |
| irq | output | 1 | Error interrupt |

## Verification
A status bit that is lost, stuck or cleared by the wrong write shows up on `irq` at the very next edge whenever its enable bit is set. With the bit masked it shows up in the next status read one clock after the strobe. A wrong response setting shows up on the first failed read, as a missing or spurious `ib_rerr` or as nonzero data one clock after `rd_done`. The random phase interleaves events, clears, enable changes and reads, so a corrupted bit is compared against the bench model within a few cycles.

// File: rtl/brg_err_pkg.sv
package brg_err_pkg;
  localparam int SRC_N  = 11;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 2;

  // register addresses
  localparam logic [ADDR_W-1:0] A_STS  = 2'd0;
  localparam logic [ADDR_W-1:0] A_ENA  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CFG  = 2'd2;
  localparam logic [ADDR_W-1:0] A_RSVD = 2'd3;

  // error source bit positions
  typedef enum int {
    SRC_TRDY_TO   = 0,
    SRC_RETRY_TO  = 1,
    SRC_BROKEN_M  = 2,
    SRC_M_DPAR    = 3,
    SRC_M_PAR     = 4,
    SRC_M_FATAL   = 5,
    SRC_PAR_DET   = 6,
    SRC_SERR_SIG  = 7,
    SRC_T_PERR    = 8,
    SRC_T_IBERR   = 9,
    SRC_SERR_SEEN = 10
  } err_src_e;

  localparam int CFG_RESP_BIT = 0;
endpackage

// File: rtl/brg_err_sticky.sv
module brg_err_sticky #(
  parameter int SRC_N = brg_err_pkg::SRC_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] evt,
  input  logic [SRC_N-1:0] clr,
  output logic [SRC_N-1:0] sts_d,
  output logic [SRC_N-1:0] sts_q
);
  for (genvar g = 0; g < SRC_N; g++) begin : g_bit
    // a new event outranks a clear in the same cycle
    always_comb sts_d[g] = evt[g] | (sts_q[g] & ~clr[g]);

    always_ff @(posedge clk) begin
      if (rst) sts_q[g] <= 1'b0;
      else     sts_q[g] <= sts_d[g];
    end

    // R2
    evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
      evt[g] |=> sts_q[g]);
    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (sts_q[g] && !clr[g]) |=> sts_q[g]);
    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (clr[g] && !evt[g]) |=> !sts_q[g]);
  end
endmodule

// File: rtl/brg_err_regs.sv
module brg_err_regs #(
  parameter int SRC_N  = brg_err_pkg::SRC_N,
  parameter int REG_W  = brg_err_pkg::REG_W,
  parameter int ADDR_W = brg_err_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [SRC_N-1:0]  sts_q,
  output logic [SRC_N-1:0]  clr,
  output logic [SRC_N-1:0]  ena_d,
  output logic [SRC_N-1:0]  ena_q,
  output logic              resp_en,
  output logic [REG_W-1:0]  rdata
);
  import brg_err_pkg::*;

  localparam int PAD_W = REG_W - SRC_N;

  logic wr_sts, wr_ena, wr_cfg;

  always_comb begin
    wr_sts = we && (addr == A_STS);
    wr_ena = we && (addr == A_ENA);
    wr_cfg = we && (addr == A_CFG);
    clr    = wr_sts ? wdata[SRC_N-1:0] : '0;
    ena_d  = wr_ena ? wdata[SRC_N-1:0] : ena_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q   <= '0;
      resp_en <= 1'b1;
    end else begin
      ena_q <= ena_d;
      if (wr_cfg) resp_en <= wdata[CFG_RESP_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      case (addr)
        A_STS:   rdata <= {{PAD_W{1'b0}}, sts_q};
        A_ENA:   rdata <= {{PAD_W{1'b0}}, ena_q};
        A_CFG:   rdata <= {{(REG_W-1){1'b0}}, resp_en};
        default: rdata <= '0;
      endcase
    end
  end

  // R5
  ena_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ena |=> (ena_q == $past(wdata[SRC_N-1:0])));
  // R10
  rsvd_read_chk: assert property (@(posedge clk) disable iff (rst)
    (re && addr == A_RSVD) |=> (rdata == '0));
  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    re |=> (rdata[REG_W-1:SRC_N] == '0));
endmodule

// File: rtl/brg_err_rdresp.sv
module brg_err_rdresp #(
  parameter int DATA_W = brg_err_pkg::REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              resp_en,
  input  logic              rd_done,
  input  logic              rd_err,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic              rerr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
      rerr   <= 1'b0;
    end else begin
      rvalid <= rd_done;
      rerr   <= rd_done & rd_err & resp_en;
      rdata  <= (rd_done && !rd_err) ? rd_data : '0;
    end
  end

  // R7
  clean_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !rd_err) |=> (rvalid && !rerr && rdata == $past(rd_data)));
  // R8
  err_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_done && rd_err && resp_en) |=> (rvalid && rerr && rdata == '0));
  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_done && rd_err && !resp_en) |=> (rvalid && !rerr && rdata == '0));
endmodule

// File: rtl/brg_err_irq.sv
module brg_err_irq #(
  parameter int SRC_N  = brg_err_pkg::SRC_N,
  parameter int REG_W  = brg_err_pkg::REG_W,
  parameter int ADDR_W = brg_err_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_N-1:0]  err_evt,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              rd_done,
  input  logic              rd_err,
  input  logic [REG_W-1:0]  rd_data,
  output logic              ib_rvalid,
  output logic [REG_W-1:0]  ib_rdata,
  output logic              ib_rerr,
  output logic              irq
);
  logic [SRC_N-1:0] sts_d, sts_q, clr, ena_d, ena_q;
  logic             resp_en;

  brg_err_sticky #(.SRC_N(SRC_N)) u_sticky (
    .clk(clk), .rst(rst), .evt(err_evt), .clr(clr),
    .sts_d(sts_d), .sts_q(sts_q)
  );

  brg_err_regs #(.SRC_N(SRC_N), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .re(reg_re), .addr(reg_addr),
    .wdata(reg_wdata), .sts_q(sts_q), .clr(clr), .ena_d(ena_d),
    .ena_q(ena_q), .resp_en(resp_en), .rdata(reg_rdata)
  );

  brg_err_rdresp #(.DATA_W(REG_W)) u_rdresp (
    .clk(clk), .rst(rst), .resp_en(resp_en), .rd_done(rd_done),
    .rd_err(rd_err), .rd_data(rd_data), .rvalid(ib_rvalid),
    .rdata(ib_rdata), .rerr(ib_rerr)
  );

  // registered from next-state values so irq moves with the registers
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(sts_d & ena_d);
  end

  // R6
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(sts_q & ena_q));
endmodule

// File: tb/test_brg_err_irq.sv
module test_brg_err_irq;
  localparam int SRC_N = 11;
  localparam int W     = 32;
  localparam logic [SRC_N-1:0] ALL = '1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [SRC_N-1:0] err_evt = '0;
  logic             reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0]       reg_addr = '0;
  logic [W-1:0]     reg_wdata = '0;
  logic [W-1:0]     reg_rdata;
  logic             rd_done = 1'b0, rd_err = 1'b0;
  logic [W-1:0]     rd_data = '0;
  logic             ib_rvalid, ib_rerr, irq;
  logic [W-1:0]     ib_rdata;

  int n_run = 0, n_fail = 0;

  // bench model
  logic [SRC_N-1:0] m_sts = '0, m_ena = '0;
  logic             m_cfg = 1'b1;

  brg_err_irq i_brg_err_irq (
    .clk(clk), .rst(rst), .err_evt(err_evt), .reg_we(reg_we),
    .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rd_done(rd_done), .rd_err(rd_err),
    .rd_data(rd_data), .ib_rvalid(ib_rvalid), .ib_rdata(ib_rdata),
    .ib_rerr(ib_rerr), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_reg(logic [1:0] a);
    case (a)
      2'd0:    return W'(m_sts);
      2'd1:    return W'(m_ena);
      2'd2:    return W'(m_cfg);
      default: return '0;
    endcase
  endfunction

  function automatic string rd_tag(logic [1:0] a);
    case (a)
      2'd0:    return "R3";
      2'd1:    return "R5";
      2'd2:    return "R9";
      default: return "R10";
    endcase
  endfunction

  // one cycle: drive on the falling edge, check just after the rising edge
  task automatic step(logic [SRC_N-1:0] evt, logic we, logic re, logic [1:0] a,
                      logic [W-1:0] wd, logic rdn, logic rde, logic [W-1:0] rdd,
                      string tag);
    logic [W-1:0] exp_rd;
    logic         pre_cfg;
    @(negedge clk);
    err_evt = evt; reg_we = we; reg_re = re; reg_addr = a; reg_wdata = wd;
    rd_done = rdn; rd_err = rde; rd_data = rdd;
    exp_rd  = model_reg(a);
    pre_cfg = m_cfg;
    if (we && a == 2'd0) m_sts = (m_sts & ~wd[SRC_N-1:0]) | evt;
    else                 m_sts = m_sts | evt;
    if (we && a == 2'd1) m_ena = wd[SRC_N-1:0];
    if (we && a == 2'd2) m_cfg = wd[0];
    @(posedge clk);
    #1;
    check("R6", W'(irq), W'(|(m_sts & m_ena)));
    if (re) check(tag == "" ? rd_tag(a) : tag, reg_rdata, exp_rd);
    if (rdn) begin
      check(rde ? (pre_cfg ? "R8" : "R9") : "R7", W'(ib_rvalid), 1);
      check(rde ? (pre_cfg ? "R8" : "R9") : "R7", W'(ib_rerr), W'(rde & pre_cfg));
      check(rde ? (pre_cfg ? "R8" : "R9") : "R7", ib_rdata, rde ? '0 : rdd);
    end else begin
      check("R7", W'(ib_rvalid), 0);
    end
  endtask

  task automatic idle();
    step('0, 0, 0, 2'd0, '0, 0, 0, '0, "");
  endtask

  task automatic rd(logic [1:0] a, string tag);
    step('0, 0, 1, a, '0, 0, 0, '0, tag);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    check("R1", W'(irq), 0);
    check("R1", W'(ib_rvalid), 0);
    rd(2'd0, "R1");
    rd(2'd1, "R1");
    rd(2'd2, "R1");

    // R2: masked event is recorded but raises nothing
    step(SRC_N'(1 << 3), 0, 0, 2'd0, '0, 0, 0, '0, "");
    idle();
    rd(2'd0, "R2");
    // R6: enabling a pending bit raises irq at once
    step('0, 1, 0, 2'd1, 32'h8, 0, 0, '0, "");
    // R4: clear and event on the same bit
    step(SRC_N'(1 << 3), 1, 0, 2'd0, 32'h8, 0, 0, '0, "");
    rd(2'd0, "R4");
    // R3: write of zeros leaves bits, write of one clears
    step('0, 1, 0, 2'd0, 32'h0, 0, 0, '0, "");
    rd(2'd0, "R3");
    step('0, 1, 0, 2'd0, 32'h8, 0, 0, '0, "");
    rd(2'd0, "R3");
    // R10 / R11
    rd(2'd3, "R10");
    step('0, 1, 0, 2'd1, 32'hFFFF_FFFF, 0, 0, '0, "");
    rd(2'd1, "R11");
    // R7 / R8 / R9
    step('0, 0, 0, 2'd0, '0, 1, 0, 32'hA5A5_1234, "R7");
    step('0, 0, 0, 2'd0, '0, 1, 1, 32'hDEAD_BEEF, "R8");
    step('0, 1, 0, 2'd2, 32'h0, 0, 0, '0, "");
    step(SRC_N'(1 << 9), 0, 0, 2'd0, '0, 1, 1, 32'h1111_2222, "R9");
    rd(2'd0, "R9");
    step('0, 1, 0, 2'd2, 32'h1, 0, 0, '0, "");
    step('0, 1, 0, 2'd0, 32'hFFFF_FFFF, 0, 0, '0, "");

    // random phase
    for (int i = 0; i < 2000; i++) begin
      logic [SRC_N-1:0] e;
      int op;
      logic we, re, rdn;
      logic [1:0] a;
      e   = ($urandom % 4 == 0) ? SRC_N'($urandom) & ALL : '0;
      op  = int'($urandom % 6);
      a   = 2'($urandom);
      we  = (op < 2);
      re  = (op == 2 || op == 3);
      if (op == 0 && a == 2'd3) a = 2'd0;
      rdn = ($urandom % 3 == 0);
      step(e, we, re, a, $urandom, rdn, 1'($urandom), $urandom, "");
    end
    idle();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule